// File: doc/BRIEF.md
# Pin Interrupt Detector Port

This block watches the 32 input pins of a general-purpose port and turns pin activity into interrupt requests. Each pin first passes through a clock-domain synchronizer. A 4-bit mode field per pin then chooses one kind of detection: off, a low level, a high level, a rising edge, a falling edge, or either edge.

A detected event sets that pin's bit in a sticky status register. Software clears status bits by writing ones to them. One interrupt line goes high whenever any status bit is set.

Software uses a simple 32-bit register bus. Each pin has a control word at byte offset 4×pin. The mode field sits in bits 19:16 of that word, and the other bits read back as zero. The status register sits at byte offset 0xA0. Reads are combinational in the cycle the select is held. Writes take effect at the clock edge.

Top module: `pinirq_port`

## Requirements
- R1: After reset, every control word and the status register read as zero and `irq_o` is low.
- R2: A write to byte offset 4×n (n = 0..31) stores bits 19:16 of the write data as pin n's mode. A read of that offset returns the mode in bits 19:16 and zero in all other bits.
- R3: Mode 0x9 sets pin n's status bit when the synchronized pin changes 0→1, and not when it changes 1→0.
- R4: Mode 0xA sets the status bit when the synchronized pin changes 1→0, and not when it changes 0→1.
- R5: Mode 0xB sets the status bit on both directions of change.
- R6: Mode 0x8 sets the status bit in every cycle the synchronized pin is low, so a clear made while the pin stays low is undone at once.
- R7: Mode 0xC sets the status bit in every cycle the synchronized pin is high, so a clear made while the pin stays high is undone at once.
- R8: Mode 0x0 and every unlisted code (for example 0xF) never set a status bit. Writing zero to a control word turns detection off for that pin.
- R9: Reading offset 0xA0 returns the status register, with bit n for pin n. Writing it clears each bit whose data bit is 1 and leaves bits written 0 unchanged, so all ones clears every flag.
- R10: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R11: `irq_o` is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Raw, unsynchronized pin levels |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe (1 = write, 0 = read) |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while selected for a read |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a clear landing in the same cycle as a new edge event on the same flag (R10).

To get there, the bench first leaves the flag set. It then moves the pin so that the next edge appears at the detector exactly three clock edges after the pin change: two synchronizer stages, then the flag register. The write-one-to-clear is timed so that it is sampled on that same edge, and the flag must then read back as still set.

The level modes are covered by clearing while the level is held and expecting the flag to return at once.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  localparam logic [3:0] MODE_OFF  = 4'h0;
  localparam logic [3:0] MODE_LOW  = 4'h8;
  localparam logic [3:0] MODE_RISE = 4'h9;
  localparam logic [3:0] MODE_FALL = 4'hA;
  localparam logic [3:0] MODE_BOTH = 4'hB;
  localparam logic [3:0] MODE_HIGH = 4'hC;

  // Event decision for one pin from its mode, present and previous sample
  function automatic logic event_hit(input logic [3:0] mode,
                                     input logic       cur,
                                     input logic       prv);
    logic hit;
    case (mode)
      MODE_LOW:  hit = ~cur;
      MODE_RISE: hit = cur & ~prv;
      MODE_FALL: hit = ~cur & prv;
      MODE_BOTH: hit = cur ^ prv;
      MODE_HIGH: hit = cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stg_d[s] = async_i;
    end else begin : g_next
      always_comb stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect
  import pinirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_i,
  input  logic       level_i,
  output logic       evt_o
);

  logic prev_q;
  logic prev_d;

  always_comb prev_d = level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  always_comb evt_o = event_hit(mode_i, level_i, prev_q);

endmodule

// File: rtl/pinirq_flags.sv
module pinirq_flags #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] set_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] flags_o
);

  logic [NPIN-1:0] flags_q;
  logic [NPIN-1:0] flags_d;
  logic            upd_en;

  // set is applied after clear, so it takes priority
  always_comb begin
    flags_d = (flags_q & ~clr_i) | set_i;
    upd_en  = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_i) & ~flags_q) == '0);

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & $past(clr_i & ~set_i)) == '0);

  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~$past(flags_q) & ~$past(set_i)) == '0);

endmodule

// File: rtl/pinirq_port.sv
module pinirq_port
  import pinirq_pkg::*;
#(
  parameter int unsigned NPIN      = 32,
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 32,
  parameter int unsigned SYNC_STG  = 2,
  parameter int unsigned FIELD_LSB = 16,
  parameter logic [7:0]  STAT_OFS  = 8'hA0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic            bus_sel_i,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            irq_o
);

  localparam int unsigned IDX_W = $clog2(NPIN);
  localparam int unsigned WRD_W = AW - 2;
  localparam logic [WRD_W-1:0] NPIN_WRD = WRD_W'(NPIN);

  logic [NPIN-1:0]  pin_sync;
  logic [NPIN-1:0]  evt_vec;
  logic [NPIN-1:0]  clr_vec;
  logic [NPIN-1:0]  flags;
  logic [3:0]       cfg_q [NPIN];
  logic [WRD_W-1:0] word_idx;
  logic [IDX_W-1:0] pin_idx;
  logic             cfg_hit;
  logic             stat_hit;
  logic             cfg_wr;
  logic             stat_wr;

  // ---------------- address decode ----------------
  always_comb begin
    word_idx = bus_addr_i[AW-1:2];
    pin_idx  = word_idx[IDX_W-1:0];
    cfg_hit  = (bus_addr_i[1:0] == 2'b00) && (word_idx < NPIN_WRD);
    stat_hit = (bus_addr_i == AW'(STAT_OFS));
    cfg_wr   = bus_sel_i & bus_we_i & cfg_hit;
    stat_wr  = bus_sel_i & bus_we_i & stat_hit;
    clr_vec  = stat_wr ? bus_wdata_i[NPIN-1:0] : '0;
  end

  // ---------------- per-pin mode registers ----------------
  for (genvar p = 0; p < NPIN; p++) begin : g_cfg
    logic       cfg_en;
    logic [3:0] cfg_d;

    always_comb begin
      cfg_en = cfg_wr && (pin_idx == IDX_W'(p));
      cfg_d  = bus_wdata_i[FIELD_LSB +: 4];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[p] <= MODE_OFF;
      else if (cfg_en) cfg_q[p] <= cfg_d;
    end
  end

  // ---------------- input synchronizer ----------------
  pinirq_sync #(
    .WIDTH  (NPIN),
    .STAGES (SYNC_STG)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  // ---------------- per-pin detectors ----------------
  for (genvar p = 0; p < NPIN; p++) begin : g_det
    pinirq_detect u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (cfg_q[p]),
      .level_i (pin_sync[p]),
      .evt_o   (evt_vec[p])
    );
  end

  // ---------------- status flags ----------------
  pinirq_flags #(
    .NPIN (NPIN)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (evt_vec),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  assign irq_o = |flags;

  // ---------------- read path ----------------
  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      if (cfg_hit)       bus_rdata_o[FIELD_LSB +: 4] = cfg_q[pin_idx];
      else if (stat_hit) bus_rdata_o[NPIN-1:0]       = flags;
    end
  end

  // R11
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(|clr_vec));

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|evt_vec));

endmodule

// File: tb/pinirq_port_bench.sv
module pinirq_port_bench;

  localparam logic [7:0] STAT = 8'hA0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin;
  logic        sel;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        rd_pend;
  int          n_run;
  int          n_fail;
  item_t       sb_q[$];

  always #4 clk = ~clk;

  pinirq_port u_pinirq_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin),
    .bus_sel_i   (sel),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; we = 1'b0;
  endtask

  // driver: pushes the expected value, then issues the read
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    @(posedge clk); #1;
    sel = 1'b1; we = 1'b0; addr = a;
    sb_q.push_back(it);
    rd_pend = 1'b1;
    @(negedge clk); #1;
    rd_pend = 1'b0; sel = 1'b0;
  endtask

  task automatic setpin(input int i, input logic v);
    @(posedge clk); #1;
    pin[i] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    chk(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (rd_pend) begin
      if (sb_q.size() == 0) begin
        chk("scoreboard empty", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.tag, rdata, it.exp);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; pin = '0; sel = 1'b0; we = 1'b0;
    addr = '0; wdata = '0; rd_pend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(STAT, 32'h0, "R1 status after reset");
    rd(8'h00, 32'h0, "R1 control word 0 after reset");
    rd(8'h7C, 32'h0, "R1 control word 31 after reset");

    // R2/R8: unlisted code 0xF stored and read back, but no detection
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h000F_0000, "R2 readback keeps only field");
    setpin(3, 1'b1); settle();
    setpin(3, 1'b0); settle();
    rd(STAT, 32'h0, "R8 unlisted code ignores toggles");

    // R3: rising edge on pin 3
    wr(8'h0C, 32'hA5A9_5A5A);
    rd(8'h0C, 32'h0009_0000, "R2 rising mode readback");
    setpin(3, 1'b1); settle();
    rd(STAT, 32'h0000_0008, "R3 rise sets flag");
    chk_irq(1'b1, "R11 irq with flag set");
    wr(STAT, 32'h0000_0008);
    rd(STAT, 32'h0, "R9 W1C clears bit 3");
    chk_irq(1'b0, "R11 irq low when clear");
    setpin(3, 1'b0); settle();
    rd(STAT, 32'h0, "R3 fall ignored in rising mode");

    // R4: falling edge on pin 0
    wr(8'h00, 32'h000A_0000);
    setpin(0, 1'b1); settle();
    rd(STAT, 32'h0, "R4 rise ignored in falling mode");
    setpin(0, 1'b0); settle();
    rd(STAT, 32'h0000_0001, "R4 fall sets flag");
    wr(STAT, 32'hFFFF_FFFF);
    rd(STAT, 32'h0, "R9 all ones clears all");

    // R5: either edge on pin 31
    wr(8'h7C, 32'h000B_0000);
    rd(8'h7C, 32'h000B_0000, "R2 last control word");
    setpin(31, 1'b1); settle();
    rd(STAT, 32'h8000_0000, "R5 rise sets flag");
    wr(STAT, 32'h7FFF_FFFF);
    rd(STAT, 32'h8000_0000, "R9 zero bits leave flag");
    wr(STAT, 32'h8000_0000);
    rd(STAT, 32'h0, "R9 bit 31 cleared");
    setpin(31, 1'b0); settle();
    rd(STAT, 32'h8000_0000, "R5 fall sets flag");
    wr(STAT, 32'h8000_0000);

    // R6: level low on pin 5 (pin already low)
    wr(8'h14, 32'h0008_0000); settle();
    rd(STAT, 32'h0000_0020, "R6 low level sets flag");
    wr(STAT, 32'h0000_0020);
    rd(STAT, 32'h0000_0020, "R6 clear undone while low");
    setpin(5, 1'b1); settle();
    wr(STAT, 32'h0000_0020);
    rd(STAT, 32'h0, "R6 clear sticks once high");

    // R7: level high on pin 7
    wr(8'h1C, 32'h000C_0000);
    setpin(7, 1'b1); settle();
    rd(STAT, 32'h0000_0080, "R7 high level sets flag");
    wr(STAT, 32'h0000_0080);
    rd(STAT, 32'h0000_0080, "R7 clear undone while high");
    setpin(7, 1'b0); settle();
    wr(STAT, 32'h0000_0080);
    rd(STAT, 32'h0, "R7 clear sticks once low");

    // R8: writing zero disables pin 3 detection
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h0, "R8 control word zeroed");
    setpin(3, 1'b1); settle();
    rd(STAT, 32'h0, "R8 disabled pin ignores rise");
    chk_irq(1'b0, "R8 irq stays low");

    // R10: clear coinciding with a new falling event on pin 0
    setpin(0, 1'b1); settle();
    setpin(0, 1'b0); settle();
    rd(STAT, 32'h0000_0001, "R10 setup flag set");
    setpin(0, 1'b1); settle();
    setpin(0, 1'b0);
    @(posedge clk);
    wr(STAT, 32'h0000_0001);
    rd(STAT, 32'h0000_0001, "R10 set wins over same-cycle clear");
    wr(STAT, 32'h0000_0001);
    rd(STAT, 32'h0, "R9 later clear takes effect");
    chk_irq(1'b0, "R11 irq low at end");

    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule